// File: doc/BRIEF.md
# Flash command sequence decoder

This block turns the stream of host write cycles aimed at a NOR-style flash into one-cycle operation strobes for an array back end. Each write carries an address and a 16-bit word, and the command byte sits in the low eight bits. Some commands take effect on a single write. Others open a sequence that later writes complete: erase and its confirm, program and its data word, a shared prefix whose second byte chooses a lock action or a partition setting, and a page-buffer load whose length comes from a word count.

Alongside the sequencer the block keeps a lock bit and a lock-down bit for every block. It refuses erase or program aimed at a locked block. It holds a small status register and selects which read source (array, identifier, query or status) the host sees. Array timing and table contents lie outside it. The back end reports busy through one input, and a hardware unlock input lets software clear a lock bit that is held by lock-down.

Top module: `fcd_top`

## Requirements
- R1: After reset `read_mode` is 0 (array). Writing FFH in idle selects 0, 90H selects 1 (identifier), 98H selects 2 (query) and 70H selects 3 (status).
- R2: `status` bit 7 is ready (the inverse of `be_busy`), bit 6 is suspended, bit 5 erase error, bit 4 program error, bit 3 sequence error and bit 1 lock violation. The other bits read 0. 50H in idle clears bits 5, 4, 3 and 1 and leaves bits 7 and 6 unchanged.
- R3: 20H then D0H strobes block erase (op code 4), and 30H then D0H strobes chip erase (op code 5). `op_addr` is the address of the cycle.
- R4: 40H or 10H, followed by a word at the same address, strobes program (op code 1) with that address and word.
- R5: When the second cycle of a two-cycle command uses a different address than the first, no strobe is issued, bit 3 is set and the decoder returns to idle.
- R6: An unknown byte in idle, or a wrong confirm or second byte, sets bit 3, issues no strobe and returns the decoder to idle.
- R7: After the 60H prefix, 01H locks the addressed block (op 6), D0H unlocks it (op 7) and 2FH sets lock-down together with lock (op 8). Erase or program aimed at a locked block issues no strobe and sets bit 1 together with bit 5 (erase) or bit 4 (program).
- R8: An unlock of a block whose lock-down bit is set is refused when `unlock_hw` is low: no strobe, bit 1 set. With `unlock_hw` high it proceeds. Lock-down bits are cleared only by reset.
- R9: E8H, then N-1, then N data words, then D0H gives one page-load strobe (op 2) per data word with its address and word, then a commit strobe (op 3) at the first address. A count N-1 above `PB_DEPTH`-1 is a sequence error. A commit aimed at a locked block is refused with bits 1 and 4 set.
- R10: 60H then 04H strobes partition configuration (op 9), and `op_addr` carries the code. C0H then a word at the same address strobes OTP program (op 10) with that word.
- R11: B0H strobes suspend (op 11) and sets bit 6. D0H in idle strobes resume (op 12) and clears bit 6.
- R12: The first cycle of 20H, 30H, 40H, 10H, C0H or E8H switches `read_mode` to 3, and the mode stays there until another read-mode command is written.
- R13: A strobe is high for exactly one cycle, in the cycle after the write that completes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write cycle valid |
| wr_addr | input | ADDR_W | Write address; top BLK_W bits select the block |
| wr_data | input | 16 | Write data; low byte is the command |
| unlock_hw | input | 1 | Hardware permission to clear a locked-down block |
| be_busy | input | 1 | Back end busy |
| op_valid | output | 1 | One-cycle operation strobe |
| op_code | output | 4 | Operation code (see requirements) |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 16 | Operation data word |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| status | output | 8 | Status register |

## Verification
The hardest case to reach is the lock-down guard. A block must first be locked down. An unlock must then be refused with the hardware input low and accepted with it high. After relocking, the unlock must be refused again, which shows the lock-down bit survived the unlock. The bench drives that whole chain and checks every step at the strobe and status ports. It then resets to show that only reset releases the bit. Alongside this, every command byte from 00H to FFH is swept from idle and followed by a fixed second byte, and page-buffer loads of every legal length plus one over the limit are applied.

// File: rtl/fcd_pkg.sv
// Shared types and command codes for the flash command decoder.
// Assumes the command byte is the low eight bits of each write word.
package fcd_pkg;
    typedef enum logic [3:0] {
        OP_NONE, OP_PROG, OP_PB_LOAD, OP_PB_COMMIT, OP_BERASE, OP_CERASE,
        OP_LOCK, OP_UNLOCK, OP_LOCKDN, OP_PCFG, OP_OTP, OP_SUSP, OP_RESUME
    } op_e;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_QUERY, RM_STATUS} rmode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ERASE, S_CHIP, S_PROG, S_OTP, S_PFX, S_PB_CNT, S_PB_DATA, S_PB_CF
    } st_e;

    typedef struct packed {
        logic seq;
        logic lockv;
        logic perr;
        logic eerr;
        logic clr;
        logic susp;
        logic res;
    } sev_t;

    localparam logic [7:0] C_RDARR  = 8'hFF;
    localparam logic [7:0] C_RDID   = 8'h90;
    localparam logic [7:0] C_RDQRY  = 8'h98;
    localparam logic [7:0] C_RDSTS  = 8'h70;
    localparam logic [7:0] C_CLRSTS = 8'h50;
    localparam logic [7:0] C_ERASE  = 8'h20;
    localparam logic [7:0] C_CHIP   = 8'h30;
    localparam logic [7:0] C_PROG_A = 8'h40;
    localparam logic [7:0] C_PROG_B = 8'h10;
    localparam logic [7:0] C_OTP    = 8'hC0;
    localparam logic [7:0] C_PFX    = 8'h60;
    localparam logic [7:0] C_PBUF   = 8'hE8;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_CONF   = 8'hD0;
    localparam logic [7:0] C_LOCK   = 8'h01;
    localparam logic [7:0] C_LOCKDN = 8'h2F;
    localparam logic [7:0] C_PCFG   = 8'h04;
endpackage

// File: rtl/fcd_lock_tbl.sv
// Per-block lock and lock-down bits.
// Assumes set/clear/lock-down requests are mutually exclusive per cycle.
module fcd_lock_tbl #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BLK_W-1:0]      q_blk,
    input  logic [BLK_W-1:0]      w_blk,
    input  logic                  set_lk,
    input  logic                  clr_lk,
    input  logic                  set_ld,
    output logic                  q_locked,
    output logic                  q_ldown,
    output logic [NUM_BLOCKS-1:0] lk_vec,
    output logic [NUM_BLOCKS-1:0] ld_vec
);
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        logic lk_r, ld_r;
        // Update this block's bits when it is the addressed block.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_r <= 1'b0;
                ld_r <= 1'b0;
            end else if (w_blk == BLK_W'(g)) begin
                if (set_lk || set_ld) lk_r <= 1'b1;
                else if (clr_lk)      lk_r <= 1'b0;
                if (set_ld)           ld_r <= 1'b1;
            end
        end
        assign lk_vec[g] = lk_r;
        assign ld_vec[g] = ld_r;
    end

    assign q_locked = lk_vec[q_blk];
    assign q_ldown  = ld_vec[q_blk];
endmodule

// File: rtl/fcd_status.sv
// Status register: ready, suspended and sticky error flags.
// Assumes a clear event never coincides with a set event.
module fcd_status
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sev_t       ev,
    input  logic       be_busy,
    output logic [7:0] status
);
    logic susp_r, eerr_r, perr_r, seq_r, lockv_r;

    // Hold suspended and the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {susp_r, eerr_r, perr_r, seq_r, lockv_r} <= '0;
        end else begin
            if (ev.susp)     susp_r <= 1'b1;
            else if (ev.res) susp_r <= 1'b0;
            if (ev.clr) begin
                {eerr_r, perr_r, seq_r, lockv_r} <= '0;
            end else begin
                eerr_r  <= eerr_r  | ev.eerr;
                perr_r  <= perr_r  | ev.perr;
                seq_r   <= seq_r   | ev.seq;
                lockv_r <= lockv_r | ev.lockv;
            end
        end
    end

    assign status = {~be_busy, susp_r, eerr_r, perr_r, seq_r, 1'b0, lockv_r, 1'b0};
endmodule

// File: rtl/fcd_seq.sv
// Command sequencer: decodes write cycles, tracks multi-cycle sequences,
// selects read mode and issues registered one-cycle operation strobes.
// Assumes lock lookups for q_blk return combinationally.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BLK_W    = 3,
    parameter int PB_DEPTH = 8,
    localparam int CNT_W   = (PB_DEPTH > 1) ? $clog2(PB_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              unlock_hw,
    input  logic              q_locked,
    input  logic              q_ldown,
    output logic [BLK_W-1:0]  q_blk,
    output logic [BLK_W-1:0]  w_blk,
    output logic              set_lk,
    output logic              clr_lk,
    output logic              set_ld,
    output sev_t              ev,
    output logic              op_valid,
    output op_e               op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output rmode_e            read_mode
);
    st_e               state, st_n;
    logic [ADDR_W-1:0] first_addr, fa_n;
    logic [CNT_W-1:0]  pb_left, left_n;
    rmode_e            mode_n;
    logic              ov_n;
    op_e               oc_n;
    logic [ADDR_W-1:0] oa_n;
    logic [7:0]        cmd;
    logic              amatch;

    assign cmd    = wr_data[7:0];
    assign amatch = (wr_addr == first_addr);
    assign w_blk  = wr_addr[ADDR_W-1 -: BLK_W];
    assign q_blk  = (state == S_PB_CF) ? first_addr[ADDR_W-1 -: BLK_W] : w_blk;

    // Next-state, strobe and event decode for the current write cycle.
    always_comb begin
        st_n   = state;
        fa_n   = first_addr;
        left_n = pb_left;
        mode_n = read_mode;
        ov_n   = 1'b0;
        oc_n   = OP_NONE;
        oa_n   = wr_addr;
        ev     = '0;
        set_lk = 1'b0;
        clr_lk = 1'b0;
        set_ld = 1'b0;
        if (wr_en) begin
            st_n = S_IDLE;
            unique case (state)
                S_IDLE: begin
                    fa_n = wr_addr;
                    case (cmd)
                        C_RDARR:  mode_n = RM_ARRAY;
                        C_RDID:   mode_n = RM_IDENT;
                        C_RDQRY:  mode_n = RM_QUERY;
                        C_RDSTS:  mode_n = RM_STATUS;
                        C_CLRSTS: ev.clr = 1'b1;
                        C_ERASE:  begin st_n = S_ERASE;  mode_n = RM_STATUS; end
                        C_CHIP:   begin st_n = S_CHIP;   mode_n = RM_STATUS; end
                        C_PROG_A,
                        C_PROG_B: begin st_n = S_PROG;   mode_n = RM_STATUS; end
                        C_OTP:    begin st_n = S_OTP;    mode_n = RM_STATUS; end
                        C_PBUF:   begin st_n = S_PB_CNT; mode_n = RM_STATUS; end
                        C_PFX:    st_n = S_PFX;
                        C_SUSP:   begin ov_n = 1'b1; oc_n = OP_SUSP;   ev.susp = 1'b1; end
                        C_CONF:   begin ov_n = 1'b1; oc_n = OP_RESUME; ev.res  = 1'b1; end
                        default:  ev.seq = 1'b1;
                    endcase
                end
                S_ERASE, S_CHIP: begin
                    if (cmd != C_CONF || !amatch) begin
                        ev.seq = 1'b1;
                    end else if (state == S_CHIP) begin
                        ov_n = 1'b1; oc_n = OP_CERASE;
                    end else if (q_locked) begin
                        ev.lockv = 1'b1; ev.eerr = 1'b1;
                    end else begin
                        ov_n = 1'b1; oc_n = OP_BERASE;
                    end
                end
                S_PROG, S_OTP: begin
                    if (!amatch) begin
                        ev.seq = 1'b1;
                    end else if (state == S_OTP) begin
                        ov_n = 1'b1; oc_n = OP_OTP;
                    end else if (q_locked) begin
                        ev.lockv = 1'b1; ev.perr = 1'b1;
                    end else begin
                        ov_n = 1'b1; oc_n = OP_PROG;
                    end
                end
                S_PFX: begin
                    if (!amatch) begin
                        ev.seq = 1'b1;
                    end else begin
                        case (cmd)
                            C_LOCK:   begin set_lk = 1'b1; ov_n = 1'b1; oc_n = OP_LOCK; end
                            C_LOCKDN: begin set_ld = 1'b1; ov_n = 1'b1; oc_n = OP_LOCKDN; end
                            C_PCFG:   begin ov_n = 1'b1; oc_n = OP_PCFG; end
                            C_CONF: begin
                                if (!q_ldown || unlock_hw) begin
                                    clr_lk = 1'b1; ov_n = 1'b1; oc_n = OP_UNLOCK;
                                end else begin
                                    ev.lockv = 1'b1;
                                end
                            end
                            default: ev.seq = 1'b1;
                        endcase
                    end
                end
                S_PB_CNT: begin
                    if (!amatch || wr_data > 16'(PB_DEPTH - 1)) begin
                        ev.seq = 1'b1;
                    end else begin
                        left_n = wr_data[CNT_W-1:0];
                        st_n   = S_PB_DATA;
                    end
                end
                S_PB_DATA: begin
                    ov_n = 1'b1; oc_n = OP_PB_LOAD;
                    if (pb_left == '0) st_n = S_PB_CF;
                    else begin
                        left_n = pb_left - 1'b1;
                        st_n   = S_PB_DATA;
                    end
                end
                S_PB_CF: begin
                    oa_n = first_addr;
                    if (cmd != C_CONF) begin
                        ev.seq = 1'b1;
                    end else if (q_locked) begin
                        ev.lockv = 1'b1; ev.perr = 1'b1;
                    end else begin
                        ov_n = 1'b1; oc_n = OP_PB_COMMIT;
                    end
                end
                default: ev.seq = 1'b1;
            endcase
        end
    end

    // Register sequence state, read mode and the outgoing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            first_addr <= '0;
            pb_left    <= '0;
            read_mode  <= RM_ARRAY;
            op_valid   <= 1'b0;
            op_code    <= OP_NONE;
            op_addr    <= '0;
            op_data    <= '0;
        end else begin
            state      <= st_n;
            first_addr <= fa_n;
            pb_left    <= left_n;
            read_mode  <= mode_n;
            op_valid   <= ov_n;
            op_code    <= oc_n;
            op_addr    <= oa_n;
            op_data    <= wr_data;
        end
    end
endmodule

// File: rtl/fcd_top.sv
// Flash command decoder top: sequencer, lock table and status register.
// Assumes NUM_BLOCKS is a power of two and at least two.
module fcd_top
    import fcd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_BLOCKS = 8,
    parameter int PB_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              unlock_hw,
    input  logic              be_busy,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [1:0]        read_mode,
    output logic [7:0]        status
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic [BLK_W-1:0]      q_blk, w_blk;
    logic                  q_locked, q_ldown, set_lk, clr_lk, set_ld;
    logic [NUM_BLOCKS-1:0] lk_vec, ld_vec;
    sev_t                  ev;
    op_e                   op_code_e;
    rmode_e                mode_e;

    fcd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PB_DEPTH(PB_DEPTH)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unlock_hw(unlock_hw), .q_locked(q_locked),
        .q_ldown(q_ldown), .q_blk(q_blk), .w_blk(w_blk), .set_lk(set_lk),
        .clr_lk(clr_lk), .set_ld(set_ld), .ev(ev), .op_valid(op_valid),
        .op_code(op_code_e), .op_addr(op_addr), .op_data(op_data),
        .read_mode(mode_e)
    );

    fcd_lock_tbl #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) lock_i (
        .clk(clk), .rst_n(rst_n), .q_blk(q_blk), .w_blk(w_blk),
        .set_lk(set_lk), .clr_lk(clr_lk), .set_ld(set_ld),
        .q_locked(q_locked), .q_ldown(q_ldown), .lk_vec(lk_vec), .ld_vec(ld_vec)
    );

    fcd_status sts_i (
        .clk(clk), .rst_n(rst_n), .ev(ev), .be_busy(be_busy), .status(status)
    );

    assign op_code   = op_code_e;
    assign read_mode = mode_e;
endmodule

// File: rtl/fcd_chk.sv
// Protocol checker for fcd_top, attached by bind.
module fcd_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [3:0]            op_code,
    input logic [BLK_W-1:0]      op_blk,
    input logic [1:0]            read_mode,
    input logic                  unlock_hw,
    input logic [NUM_BLOCKS-1:0] lk_vec,
    input logic [NUM_BLOCKS-1:0] ld_vec
);
    localparam logic [NUM_BLOCKS-1:0] ONE = NUM_BLOCKS'(1);

    logic two_cyc;
    assign two_cyc = op_valid && (op_code == 4'd1 || op_code == 4'd4 || op_code == 4'd5 ||
                     op_code == 4'd6 || op_code == 4'd7 || op_code == 4'd8 ||
                     op_code == 4'd9 || op_code == 4'd10);

    // R7: no erase, program or commit on a block that was locked
    a_r7_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd1 || op_code == 4'd3 || op_code == 4'd4))
        |-> ((($past(lk_vec) >> op_blk) & ONE) == '0));

    // R8: unlock only when lock-down was clear or hardware permitted it
    a_r8_unlock_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7)
        |-> (((($past(ld_vec) >> op_blk) & ONE) == '0) || $past(unlock_hw)));

    // R8: lock-down bits never clear outside reset
    a_r8_ldown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ld_vec & $past(ld_vec)) == $past(ld_vec)));

    // R12: program and erase strobes come with status read mode
    a_r12_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd1 || op_code == 4'd3 || op_code == 4'd4 ||
                      op_code == 4'd5 || op_code == 4'd10))
        |-> (read_mode == 2'd3));

    // R13: the opening cycle of a two-cycle command issues no strobe
    a_r13_first_cycle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        two_cyc |-> $past(!op_valid));
endmodule

bind fcd_top fcd_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_blk(op_addr[ADDR_W-1 -: BLK_W]), .read_mode(read_mode),
    .unlock_hw(unlock_hw), .lk_vec(lk_vec), .ld_vec(ld_vec)
);

// File: tb/fcd_top_tb_top.sv
module fcd_top_tb_top;
    localparam int AW = 12;
    localparam int NB = 8;
    localparam int PBD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          unlock_hw = 1'b0;
    logic          be_busy = 1'b0;
    logic          op_valid;
    logic [3:0]    op_code;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [1:0]    read_mode;
    logic [7:0]    status;

    int n_chk = 0;
    int n_bad = 0;
    int cap_v, cap_c, cap_a, cap_d;
    int susp_e;

    always #2.5 clk = ~clk;

    fcd_top #(.ADDR_W(AW), .NUM_BLOCKS(NB), .PB_DEPTH(PBD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unlock_hw(unlock_hw), .be_busy(be_busy),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .read_mode(read_mode), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write cycle; strobe outputs are captured at the following negedge.
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
        cap_v = int'(op_valid);
        cap_c = op_valid ? int'(op_code) : -1;
        cap_a = int'(op_addr);
        cap_d = int'(op_data);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        susp_e = 0;
    endtask

    function automatic int sts(input int e, input int p, input int s, input int l);
        return 32'h80 | (susp_e << 6) | (e << 5) | (p << 4) | (s << 3) | (l << 1);
    endfunction

    function automatic bit known(input int b);
        return b == 'hFF || b == 'h90 || b == 'h98 || b == 'h70 || b == 'h50 ||
               b == 'h20 || b == 'h30 || b == 'h40 || b == 'h10 || b == 'hC0 ||
               b == 'h60 || b == 'hE8 || b == 'hB0 || b == 'hD0;
    endfunction

    function automatic int baddr(input int b, input int off);
        return (b << 9) | off;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 R2 reset state
        chk("R1 reset mode", int'(read_mode), 0);
        chk("R2 reset status", int'(status), 'h80);
        chk("R13 reset strobe", int'(op_valid), 0);

        // Sweep every command byte from idle, then FFH as second byte.
        for (int b = 0; b < 256; b++) begin
            int e_op, e_mode, e_seq, e2_op;
            wr('h010, 'h50);
            wr('h010, b);
            e_op = (b == 'hB0) ? 11 : (b == 'hD0) ? 12 : -1;
            if (b == 'hB0) susp_e = 1;
            if (b == 'hD0) susp_e = 0;
            case (b)
                'h90: e_mode = 1;
                'h98: e_mode = 2;
                'h70, 'h20, 'h30, 'h40, 'h10, 'hC0, 'hE8: e_mode = 3;
                default: e_mode = 0;
            endcase
            e_seq = known(b) ? 0 : 1;
            chk($sformatf("R11 R6 op after byte %0h", b), cap_c, e_op);
            chk($sformatf("R1 R12 mode after byte %0h", b), int'(read_mode), e_mode);
            chk($sformatf("R6 R2 status after byte %0h", b), int'(status), sts(0, 0, e_seq, 0));
            wr('h010, 'hFF);
            e2_op = (b == 'h40 || b == 'h10) ? 1 : (b == 'hC0) ? 10 : -1;
            if (b == 'h20 || b == 'h30 || b == 'h60 || b == 'hE8) e_seq = 1;
            chk($sformatf("R4 R10 second op byte %0h", b), cap_c, e2_op);
            if (e2_op != -1) chk("R4 second data", cap_d, 'hFF);
            chk($sformatf("R6 second status byte %0h", b), int'(status), sts(0, 0, e_seq, 0));
            wr('h010, 'hFF);
        end

        // R3 erase every block, R5 address mismatch
        for (int b = 0; b < NB; b++) begin
            wr(baddr(b, 'h33), 'h20);
            wr(baddr(b, 'h33), 'hD0);
            chk("R3 block erase", cap_c, 4);
            chk("R3 erase addr", cap_a, baddr(b, 'h33));
            @(negedge clk);
            chk("R13 strobe one cycle", int'(op_valid), 0);
        end
        wr('h100, 'h30); wr('h100, 'hD0);
        chk("R3 chip erase", cap_c, 5);
        wr('h100, 'h20); wr('h101, 'hD0);
        chk("R5 mismatch no strobe", cap_c, -1);
        chk("R5 mismatch status", int'(status), sts(0, 0, 1, 0));
        wr('h100, 'h40); wr('h102, 'h1234);
        chk("R5 program mismatch", cap_c, -1);
        wr('h100, 'h50);
        chk("R2 clear", int'(status), sts(0, 0, 0, 0));
        wr('h2A4, 'h10); wr('h2A4, 'hBEEF);
        chk("R4 program op", cap_c, 1);
        chk("R4 program data", cap_d, 'hBEEF);
        chk("R4 program addr", cap_a, 'h2A4);

        // R7 lock each block and try erasing every block
        for (int b = 0; b < NB; b++) begin
            wr(baddr(b, 5), 'h60); wr(baddr(b, 5), 'h01);
            chk("R7 lock op", cap_c, 6);
            for (int c = 0; c < NB; c++) begin
                wr(baddr(c, 7), 'h20); wr(baddr(c, 7), 'hD0);
                chk($sformatf("R7 erase blk %0d lock %0d", c, b), cap_c, (c == b) ? -1 : 4);
            end
            chk("R7 erase refused status", int'(status), sts(1, 0, 0, 1));
            wr('h0, 'h50);
            wr(baddr(b, 9), 'h40); wr(baddr(b, 9), 'h5555);
            chk("R7 program refused", cap_c, -1);
            chk("R7 program refused status", int'(status), sts(0, 1, 0, 1));
            wr('h0, 'h50);
            wr(baddr(b, 5), 'h60); wr(baddr(b, 5), 'hD0);
            chk("R7 unlock op", cap_c, 7);
        end

        // R8 lock-down chain
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'h2F);
        chk("R8 lockdown op", cap_c, 8);
        wr(baddr(2, 0), 'h20); wr(baddr(2, 0), 'hD0);
        chk("R8 erase refused", cap_c, -1);
        wr('h0, 'h50);
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'hD0);
        chk("R8 unlock refused", cap_c, -1);
        chk("R8 refused status", int'(status), sts(0, 0, 0, 1));
        wr('h0, 'h50);
        unlock_hw = 1'b1;
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'hD0);
        chk("R8 hw unlock", cap_c, 7);
        unlock_hw = 1'b0;
        wr(baddr(2, 0), 'h20); wr(baddr(2, 0), 'hD0);
        chk("R8 erase after hw unlock", cap_c, 4);
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'h01);
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'hD0);
        chk("R8 lockdown sticky", cap_c, -1);
        do_reset();
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'h01);
        wr(baddr(2, 0), 'h60); wr(baddr(2, 0), 'hD0);
        chk("R8 reset releases lockdown", cap_c, 7);

        // R9 page buffer of every length, then overflow and locked commit
        for (int n = 1; n <= PBD; n++) begin
            wr(baddr(3, 0), 'hE8);
            wr(baddr(3, 0), n - 1);
            chk("R9 count no strobe", cap_c, -1);
            for (int i = 0; i < n; i++) begin
                wr(baddr(3, i), i * 3 + n);
                chk("R9 load op", cap_c, 2);
                chk("R9 load addr", cap_a, baddr(3, i));
                chk("R9 load data", cap_d, i * 3 + n);
            end
            wr(baddr(3, 0), 'hD0);
            chk("R9 commit op", cap_c, 3);
            chk("R9 commit addr", cap_a, baddr(3, 0));
        end
        chk("R9 status clean", int'(status), sts(0, 0, 0, 0));
        wr(baddr(3, 0), 'hE8); wr(baddr(3, 0), PBD);
        chk("R9 overflow status", int'(status), sts(0, 0, 1, 0));
        wr(baddr(3, 0), 'h1234);
        chk("R9 overflow back to idle", cap_c, -1);
        wr('h0, 'h50);
        wr(baddr(4, 0), 'h60); wr(baddr(4, 0), 'h01);
        wr(baddr(4, 0), 'hE8); wr(baddr(4, 0), 0);
        wr(baddr(4, 1), 'h77);
        wr(baddr(4, 0), 'hD0);
        chk("R9 locked commit refused", cap_c, -1);
        chk("R9 locked commit status", int'(status), sts(0, 1, 0, 1));
        wr('h0, 'h50);

        // R10 partition configuration, OTP, bad prefix second byte
        wr('h5A5, 'h60); wr('h5A5, 'h04);
        chk("R10 pcfg op", cap_c, 9);
        chk("R10 pcfg code", cap_a, 'h5A5);
        wr('h044, 'hC0); wr('h044, 'hCAFE);
        chk("R10 otp op", cap_c, 10);
        chk("R10 otp data", cap_d, 'hCAFE);
        wr('h044, 'h60); wr('h044, 'h02);
        chk("R6 bad prefix byte", cap_c, -1);
        chk("R6 bad prefix status", int'(status), sts(0, 0, 1, 0));

        // R11 suspend/resume and R2 clear keeps suspended and ready
        wr('h0, 'hB0);
        susp_e = 1;
        chk("R11 suspend op", cap_c, 11);
        wr('h0, 'h50);
        chk("R2 clear keeps suspended", int'(status), sts(0, 0, 0, 0));
        be_busy = 1'b1;
        @(negedge clk);
        chk("R2 busy clears ready", int'(status), sts(0, 0, 0, 0) & 'h7F);
        be_busy = 1'b0;
        wr('h0, 'hD0);
        susp_e = 0;
        chk("R11 resume op", cap_c, 12);
        chk("R11 resume status", int'(status), sts(0, 0, 0, 0));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule